// File: doc/BRIEF.md
# Single-Wire Transceiver Mode and Wake Controller

This block is the digital control core of a single-wire bus transceiver. Two mode-select inputs choose one of four operating modes: sleep, high-voltage wake-up transmit, high-speed, or normal. From the selected mode and a set of digitised status flags, the block drives the bus-driver enable and data, the receiver enable, the receive-data output and the load-switch control.

A sleep/wake state machine drives the regulator-enable output. A rising high-voltage wake level on the bus raises the output. A non-sleep mode selected by firmware also raises it and keeps it high. Once the mode returns to sleep, the output is held for a long timeout and then dropped, even if the wake level is still on the bus.

All delays are counted in periods of an external reference tick. Every asynchronous input passes through a two-flop synchroniser, so each input acts two clocks after it changes.

Top module: `swc_mode_ctrl`

## Requirements
- R1: The mode is decoded from the pair {mode0_i, mode1_i}, with mode0_i as the most significant bit: 00 is sleep, 01 is high-voltage wake-up transmit (hv_lvl_o=1), 10 is high-speed (fast_o=1), and 11 is normal (hv_lvl_o=0 and fast_o=0). hv_lvl_o and fast_o are never both 1.
- R2: After reset the block is in sleep. reg_en_o=0, rxd_o=1, drv_en_o=0 and drv_dom_o=0.
- R3: Outside sleep, with the driver allowed, txd_i=0 gives drv_dom_o=1 and drv_en_o=1. txd_i=1 gives drv_dom_o=0. After txd_i returns to 1, drv_en_o stays 1 for TAIL_TICKS ticks and then falls. In sleep, drv_en_o and drv_dom_o are both 0.
- R4: In any non-sleep mode without under-voltage, rxd_o equals the inverse of bus_dom_i.
- R5: In sleep, with no wake level present and the release window over, rxd_o is 1 whatever the bus state.
- R6: In sleep, while hv_wake_i is 1, rxd_o follows the inverse of bus_dom_i. After hv_wake_i falls, rxd_o keeps following the bus for REL_TICKS ticks and then returns to 1.
- R7: While asleep, a rising edge of hv_wake_i or a non-sleep mode sets reg_en_o to 1.
- R8: While awake, a non-sleep mode keeps reg_en_o at 1. With mode 00, reg_en_o falls after HOLD_TICKS ticks. The count restarts on every edge of hv_wake_i and whenever a non-sleep mode is selected.
- R9: Once the hold count expires, reg_en_o falls even if hv_wake_i is still 1. A held wake level does not wake the block again; only a new rising edge does.
- R10: With uv_i=1, drv_en_o=0, drv_dom_o=0, rx_en_o=0 and rxd_o=1.
- R11: With ot_i=1, drv_en_o=0 and drv_dom_o=0, while rxd_o still follows the bus.
- R12: load_sw_o is 0 while lgnd_i=1 and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock reference tick that paces all timers |
| mode0_i | input | 1 | Mode select, most significant bit |
| mode1_i | input | 1 | Mode select, least significant bit |
| txd_i | input | 1 | Transmit data, 0 requests the dominant state |
| hv_wake_i | input | 1 | High-voltage wake level detected on the bus |
| bus_dom_i | input | 1 | Bus is in a dominant state |
| uv_i | input | 1 | Supply under-voltage flag |
| ot_i | input | 1 | Over-temperature flag |
| lgnd_i | input | 1 | Loss-of-ground flag |
| drv_en_o | output | 1 | Bus driver enable |
| drv_dom_o | output | 1 | Drive the bus dominant |
| hv_lvl_o | output | 1 | Use the high-voltage dominant level |
| fast_o | output | 1 | Bypass waveshaping for the high-speed rate |
| rx_en_o | output | 1 | Receiver enable |
| rxd_o | output | 1 | Receive data, 1 for a recessive bus |
| reg_en_o | output | 1 | Regulator enable |
| load_sw_o | output | 1 | Load switch closed |

## Verification
After the wake level ends in sleep, two timers run at the same time. The receive-release window is short and the regulator hold countdown is long, and both start from the same falling edge of hv_wake_i. The bench drops the wake level while the bus is dominant. It first checks that rxd_o is released while reg_en_o is still high, and then that reg_en_o falls only within the hold window. In a second case the wake level is left on the bus across the hold expiry, and the bench checks that rxd_o keeps following the bus while reg_en_o drops and stays low.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    MD_SLEEP = 2'b00,
    MD_HVWU  = 2'b01,
    MD_FAST  = 2'b10,
    MD_NORM  = 2'b11
  } swc_mode_e;

  localparam int unsigned NUM_SYNC = 8;
  localparam int unsigned SI_MODE0 = 0;
  localparam int unsigned SI_MODE1 = 1;
  localparam int unsigned SI_TXD   = 2;
  localparam int unsigned SI_HV    = 3;
  localparam int unsigned SI_DOM   = 4;
  localparam int unsigned SI_UV    = 5;
  localparam int unsigned SI_OT    = 6;
  localparam int unsigned SI_LGND  = 7;
  // txd resets recessive, everything else low
  localparam logic [NUM_SYNC-1:0] SYNC_RST = NUM_SYNC'(1) << SI_TXD;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int unsigned    WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/swc_tick_timer.sv
module swc_tick_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last     = (cnt_q == CW'(LIMIT - 1));
  assign expire_o = !clr_i && run_i && tick_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || expire_o) cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/swc_wake_ctrl.sv
module swc_wake_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 250000,
  parameter int unsigned REL_TICKS  = 20
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  swc_mode_e mode_i,
  input  logic      hv_i,
  output logic      awake_o,
  output logic      rx_open_o
);
  logic hv_d_q, awake_q, open_q;
  logic hv_rise, hv_fall, is_sleep;
  logic hold_clr, hold_exp, rel_clr, rel_exp;

  assign is_sleep = (mode_i == MD_SLEEP);
  assign hv_rise  = hv_i & ~hv_d_q;
  assign hv_fall  = ~hv_i & hv_d_q;

  // hold restarts on any wake-level edge or firmware non-sleep request
  assign hold_clr = !awake_q || !is_sleep || hv_rise || hv_fall;
  assign rel_clr  = hv_i || !open_q;

  swc_tick_timer #(.LIMIT(HOLD_TICKS)) u_hold (
    .clk_i, .rst_ni, .tick_i,
    .clr_i(hold_clr), .run_i(awake_q), .expire_o(hold_exp)
  );

  swc_tick_timer #(.LIMIT(REL_TICKS)) u_rel (
    .clk_i, .rst_ni, .tick_i,
    .clr_i(rel_clr), .run_i(open_q), .expire_o(rel_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv_d_q  <= 1'b0;
      awake_q <= 1'b0;
      open_q  <= 1'b0;
    end else begin
      hv_d_q <= hv_i;
      if (!awake_q)      awake_q <= hv_rise || !is_sleep;
      else if (hold_exp) awake_q <= 1'b0;
      if (hv_i)          open_q <= 1'b1;
      else if (rel_exp)  open_q <= 1'b0;
    end
  end

  assign awake_o   = awake_q;
  assign rx_open_o = open_q;
endmodule

// File: rtl/swc_tx_ctrl.sv
module swc_tx_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned TAIL_TICKS = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  swc_mode_e mode_i,
  input  logic      txd_i,
  input  logic      uv_i,
  input  logic      ot_i,
  output logic      drv_en_o,
  output logic      drv_dom_o
);
  logic drv_ok, tail_q, tail_exp;

  assign drv_ok = (mode_i != MD_SLEEP) && !uv_i && !ot_i;

  swc_tick_timer #(.LIMIT(TAIL_TICKS)) u_tail (
    .clk_i, .rst_ni, .tick_i,
    .clr_i(!txd_i || !tail_q), .run_i(tail_q), .expire_o(tail_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tail_q <= 1'b0;
    else if (!drv_ok)  tail_q <= 1'b0;
    else if (!txd_i)   tail_q <= 1'b1;
    else if (tail_exp) tail_q <= 1'b0;
  end

  assign drv_dom_o = drv_ok & ~txd_i;
  assign drv_en_o  = drv_dom_o | (drv_ok & tail_q);
endmodule

// File: rtl/swc_mode_ctrl.sv
module swc_mode_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 250000,
  parameter int unsigned REL_TICKS  = 20,
  parameter int unsigned TAIL_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic mode0_i,
  input  logic mode1_i,
  input  logic txd_i,
  input  logic hv_wake_i,
  input  logic bus_dom_i,
  input  logic uv_i,
  input  logic ot_i,
  input  logic lgnd_i,
  output logic drv_en_o,
  output logic drv_dom_o,
  output logic hv_lvl_o,
  output logic fast_o,
  output logic rx_en_o,
  output logic rxd_o,
  output logic reg_en_o,
  output logic load_sw_o
);
  logic [NUM_SYNC-1:0] raw, syn;
  swc_mode_e mode_s;
  logic txd_s, hv_s, dom_s, uv_s, ot_s, lgnd_s;
  logic rx_open;

  always_comb begin
    raw           = '0;
    raw[SI_MODE0] = mode0_i;
    raw[SI_MODE1] = mode1_i;
    raw[SI_TXD]   = txd_i;
    raw[SI_HV]    = hv_wake_i;
    raw[SI_DOM]   = bus_dom_i;
    raw[SI_UV]    = uv_i;
    raw[SI_OT]    = ot_i;
    raw[SI_LGND]  = lgnd_i;
  end

  swc_sync #(.WIDTH(NUM_SYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  assign mode_s = swc_mode_e'({syn[SI_MODE0], syn[SI_MODE1]});
  assign txd_s  = syn[SI_TXD];
  assign hv_s   = syn[SI_HV];
  assign dom_s  = syn[SI_DOM];
  assign uv_s   = syn[SI_UV];
  assign ot_s   = syn[SI_OT];
  assign lgnd_s = syn[SI_LGND];

  swc_wake_ctrl #(.HOLD_TICKS(HOLD_TICKS), .REL_TICKS(REL_TICKS)) u_wake (
    .clk_i, .rst_ni, .tick_i,
    .mode_i(mode_s), .hv_i(hv_s),
    .awake_o(reg_en_o), .rx_open_o(rx_open)
  );

  swc_tx_ctrl #(.TAIL_TICKS(TAIL_TICKS)) u_tx (
    .clk_i, .rst_ni, .tick_i,
    .mode_i(mode_s), .txd_i(txd_s), .uv_i(uv_s), .ot_i(ot_s),
    .drv_en_o, .drv_dom_o
  );

  assign hv_lvl_o  = (mode_s == MD_HVWU);
  assign fast_o    = (mode_s == MD_FAST);
  assign rx_en_o   = ~uv_s;
  assign load_sw_o = ~lgnd_s;

  // in sleep the receive path is released unless a wake window is open
  always_comb begin
    if (uv_s)                                rxd_o = 1'b1;
    else if (mode_s != MD_SLEEP || rx_open)  rxd_o = ~dom_s;
    else                                     rxd_o = 1'b1;
  end
endmodule

// File: rtl/swc_mode_ctrl_chk.sv
module swc_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_s,
  input logic       hv_s,
  input logic       uv_s,
  input logic       ot_s,
  input logic       lgnd_s,
  input logic       drv_en_o,
  input logic       drv_dom_o,
  input logic       hv_lvl_o,
  input logic       fast_o,
  input logic       rx_en_o,
  input logic       rxd_o,
  input logic       reg_en_o,
  input logic       load_sw_o
);
  AST_LEVEL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hv_lvl_o, fast_o})); // R1
  AST_DOM_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_dom_o |-> drv_en_o); // R3
  AST_SLEEP_NO_DRV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_s == 2'b00) |-> !drv_en_o); // R3
  AST_WAKE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_en_o) |-> ($past(mode_s) != 2'b00 || $past(hv_s))); // R7
  AST_DROP_IN_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reg_en_o) |-> ($past(mode_s) == 2'b00)); // R8
  AST_UV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_s |-> (!drv_en_o && !drv_dom_o && !rx_en_o && rxd_o)); // R10
  AST_OT_DRV_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_s |-> (!drv_en_o && !drv_dom_o)); // R11
  AST_LOAD_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lgnd_s |-> !load_sw_o); // R12
endmodule

bind swc_mode_ctrl swc_mode_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_s(mode_s), .hv_s(hv_s),
  .uv_s(uv_s), .ot_s(ot_s), .lgnd_s(lgnd_s),
  .drv_en_o(drv_en_o), .drv_dom_o(drv_dom_o), .hv_lvl_o(hv_lvl_o),
  .fast_o(fast_o), .rx_en_o(rx_en_o), .rxd_o(rxd_o),
  .reg_en_o(reg_en_o), .load_sw_o(load_sw_o)
);

// File: tb/sim_swc_mode_ctrl.sv
module sim_swc_mode_ctrl;
  localparam int unsigned HOLD = 40;
  localparam int unsigned REL  = 5;
  localparam int unsigned TAIL = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic m0 = 1'b0, m1 = 1'b0, txd = 1'b1, hv = 1'b0, dom = 1'b0;
  logic uv = 1'b0, ot = 1'b0, lg = 1'b0;
  logic drv_en, drv_dom, hv_lvl, fast, rx_en, rxd, reg_en, load_sw;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  swc_mode_ctrl #(.HOLD_TICKS(HOLD), .REL_TICKS(REL), .TAIL_TICKS(TAIL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode0_i(m0), .mode1_i(m1),
    .txd_i(txd), .hv_wake_i(hv), .bus_dom_i(dom), .uv_i(uv), .ot_i(ot),
    .lgnd_i(lg), .drv_en_o(drv_en), .drv_dom_o(drv_dom), .hv_lvl_o(hv_lvl),
    .fast_o(fast), .rx_en_o(rx_en), .rxd_o(rxd), .reg_en_o(reg_en),
    .load_sw_o(load_sw)
  );

  // tick every 4 clocks, driven away from the active edge
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      tick = (c == 3);
      c = (c + 1) % 4;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    {m0, m1} = m;
  endtask

  function automatic logic e_drv(input logic [1:0] m, input logic t, input logic u, input logic o);
    return (m != 2'b00) && !u && !o && !t;
  endfunction
  function automatic logic e_rxd(input logic [1:0] m, input logic d, input logic u);
    return u ? 1'b1 : ((m != 2'b00) ? !d : 1'b1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    cyc(5);
    @(negedge clk); rst_n = 1'b1;
    cyc(3);
    chk("R2", "reg_en", reg_en, 1'b0);
    chk("R2", "rxd", rxd, 1'b1);
    chk("R2", "drv_en", drv_en, 1'b0);
    chk("R2", "drv_dom", drv_dom, 1'b0);
    chk("R12", "load_sw", load_sw, 1'b1);

    // sleep: transmitter off, receive released
    @(negedge clk); txd = 1'b0; dom = 1'b1;
    cyc(10);
    chk("R3", "sleep drv_en", drv_en, 1'b0);
    chk("R3", "sleep drv_dom", drv_dom, 1'b0);
    chk("R5", "sleep rxd", rxd, 1'b1);
    chk("R7", "no wake", reg_en, 1'b0);
    @(negedge clk); txd = 1'b1;

    // wake from the bus, rx follows, release window, hold timer
    @(negedge clk); hv = 1'b1;
    cyc(6);
    chk("R7", "hv wake", reg_en, 1'b1);
    chk("R6", "rx dominant", rxd, 1'b0);
    @(negedge clk); dom = 1'b0;
    cyc(4);
    chk("R6", "rx recessive", rxd, 1'b1);
    @(negedge clk); dom = 1'b1;
    cyc(4);
    @(negedge clk); hv = 1'b0;
    cyc(8);
    chk("R6", "window open", rxd, 1'b0);
    cyc(32);
    chk("R6", "window closed", rxd, 1'b1);
    chk("R8", "still held", reg_en, 1'b1);
    cyc(105);
    chk("R8", "held near end", reg_en, 1'b1);
    cyc(35);
    chk("R8", "dropped", reg_en, 1'b0);

    // wake level left on the bus across expiry
    @(negedge clk); dom = 1'b0; hv = 1'b1;
    cyc(6);
    chk("R7", "rewake", reg_en, 1'b1);
    cyc(139);
    chk("R9", "held", reg_en, 1'b1);
    cyc(35);
    chk("R9", "drop with hv", reg_en, 1'b0);
    cyc(40);
    chk("R9", "no rewake on level", reg_en, 1'b0);
    @(negedge clk); dom = 1'b1;
    cyc(4);
    chk("R6", "rx follows hv asleep", rxd, 1'b0);
    @(negedge clk); hv = 1'b0; dom = 1'b0;
    cyc(40);

    // firmware keeps the regulator up
    set_mode(2'b11);
    cyc(6);
    chk("R7", "mode wake", reg_en, 1'b1);
    cyc(250);
    chk("R8", "non-sleep hold", reg_en, 1'b1);
    set_mode(2'b00);
    cyc(145);
    chk("R8", "hold after mode", reg_en, 1'b1);
    cyc(35);
    chk("R8", "drop after mode", reg_en, 1'b0);

    // mode decode
    for (int m = 1; m < 4; m++) begin
      set_mode(2'(m));
      cyc(5);
      chk("R1", "hv_lvl", hv_lvl, (m == 1));
      chk("R1", "fast", fast, (m == 2));
    end

    // transmit tail
    @(negedge clk); txd = 1'b0;
    cyc(6);
    chk("R3", "dom", drv_dom, 1'b1);
    chk("R3", "en", drv_en, 1'b1);
    @(negedge clk); txd = 1'b1;
    cyc(4);
    chk("R3", "tail dom", drv_dom, 1'b0);
    chk("R3", "tail en", drv_en, 1'b1);
    cyc(20);
    chk("R3", "tail over", drv_en, 1'b0);

    // faults
    @(negedge clk); uv = 1'b1; txd = 1'b0; dom = 1'b1;
    cyc(6);
    chk("R10", "uv drv_en", drv_en, 1'b0);
    chk("R10", "uv rxd", rxd, 1'b1);
    chk("R10", "uv rx_en", rx_en, 1'b0);
    @(negedge clk); uv = 1'b0; ot = 1'b1;
    cyc(6);
    chk("R11", "ot drv_en", drv_en, 1'b0);
    chk("R11", "ot rxd", rxd, 1'b0);
    @(negedge clk); ot = 1'b0; lg = 1'b1;
    cyc(6);
    chk("R12", "lgnd", load_sw, 1'b0);
    @(negedge clk); lg = 1'b0; txd = 1'b1;
    cyc(24);

    // random steady-state patterns in non-sleep modes
    for (int i = 0; i < 60; i++) begin
      logic [1:0] m;
      logic t, d, u, o, l;
      m = 2'(1 + ($urandom % 3));
      t = 1'($urandom); d = 1'($urandom); l = 1'($urandom);
      u = (($urandom % 5) == 0); o = (($urandom % 5) == 0);
      @(negedge clk);
      {m0, m1} = m; txd = t; dom = d; uv = u; ot = o; lg = l;
      cyc(24);
      chk("R3", "rnd drv_dom", drv_dom, e_drv(m, t, u, o));
      chk("R3", "rnd drv_en", drv_en, e_drv(m, t, u, o));
      chk("R4", "rnd rxd", rxd, e_rxd(m, d, u));
      chk("R10", "rnd rx_en", rx_en, !u);
      chk("R1", "rnd hv_lvl", hv_lvl, (m == 2'b01));
      chk("R1", "rnd fast", fast, (m == 2'b10));
      chk("R12", "rnd load_sw", load_sw, !l);
      chk("R7", "rnd reg_en", reg_en, 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule